// File: doc/BRIEF.md
# Keyed Four-Stage Watchdog Timer

This block is a watchdog that runs through four timeout stages in turn. Each stage has its own hold count and its own action. A stage either does nothing, raises an interrupt, resets the CPUs, resets the system, or resets the always-on domain. After stage 3 the sequence wraps back to stage 0. Software keeps the sequence from advancing by feeding the watchdog, which returns it to the start of stage 0. A 2-bit fuse value, taken as an input, stretches the stage-0 period. Reset actions come out as pulses whose width is chosen by a 3-bit code.

All configuration sits behind a write-protect key register. A boot mode keeps the timer running even when the main enable is clear. A pause control freezes counting while the sleep input is high. The interrupt has a raw status bit, an enable bit and a write-1 clear.

Top module: `tiered_wdt`

## Requirements
- R1: Writes to the control, hold and feed registers take effect only while unlocked. Writing 0x50D83AA1 to the key register (address 0) unlocks the block, and writing any other value locks it. Reading address 0 returns the unlocked flag in bit 0. Reset leaves the block locked.
- R2: Stages run in order 0, 1, 2, 3 and then return to 0. Stages 1 to 3 each expire after their hold value in counting cycles (hold registers at addresses 3, 4 and 5). Reading address 6 returns the current stage in bits [1:0].
- R3: Stage 0 (hold at address 2) expires after hold × 2^(1+fuseSel) counting cycles.
- R4: Each stage's action is a 3-bit field in the control register (address 1), with stage s at bits [14+4s:12+4s]. The codes are: 0 none, 1 set interrupt status, 2 CPU reset, 3 system reset, 4 always-on reset, and 5 to 7 none. An action takes effect at the clock edge where its stage expires.
- R5: A reset pulse is high for ceil(t / clock period) cycles. The time t is 100, 200, 300, 400, 500, 800, 1600 or 3200 ns for codes 0 to 7. The CPU width code is at control bits [7:5]. The system width code is at bits [10:8] and applies to both the system and the always-on pulses.
- R6: A CPU-reset action pulses cpu0Rst only if control bit 3 is set, and pulses cpu1Rst only if control bit 4 is set.
- R7: Writing 1 in bit 0 of address 6 while unlocked clears the count and returns to stage 0.
- R8: The counter runs when the enable bit (control bit 0) or the boot-mode bit (control bit 1) is set. With both bits clear, it holds.
- R9: When pause-in-sleep (control bit 2) is set, the counter freezes while sleepIn is high. When the bit is clear, sleepIn has no effect.
- R10: Interrupt status is read at address 8. Interrupt enable is bit 0 of address 7, and writing 1 in bit 0 of address 9 clears the status. Addresses 7 and 9 can be written while locked. irqOut is high exactly when both status and enable are high.
- R11: After reset, all reset outputs and irqOut are low, the control register reads 0, and the stage is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWe | input | 1 | Register write strobe |
| regAddr | input | 4 | Register address |
| regWdata | input | 32 | Write data |
| regRdata | output | 32 | Read data, combinational from regAddr |
| fuseSel | input | 2 | Stage-0 period scale from fuses |
| sleepIn | input | 1 | Sleep indication |
| irqOut | output | 1 | Interrupt request |
| cpu0Rst | output | 1 | CPU0 reset pulse |
| cpu1Rst | output | 1 | CPU1 reset pulse |
| sysRst | output | 1 | System reset pulse |
| aonRst | output | 1 | Always-on domain reset pulse |

## Verification
A register write takes effect at the rising edge that samples it, and read data is valid a fraction of a cycle after the address settles. If the counter is enabled at edge E0, the stage's action appears just after edge E0+N, where N is the accumulated stage limit plus any cycles frozen by sleep. A reset pulse then stays high for exactly its coded width. The bench drives and samples on falling edges. It counts the falling edges from the enabling write until an output rises, and again while the output stays high. Each count is compared with N or with the width derived from the code table.

// File: rtl/wdt_pkg.sv
`timescale 1ns/1ps
package wdt_pkg;
  localparam int STAGES  = 4;
  localparam int STAGE_W = $clog2(STAGES);
  localparam int HOLD_W  = 32;
  localparam int LIMIT_W = HOLD_W + 4;
  localparam int ADDR_W  = 4;
  localparam int CODE_W  = 3;
  localparam int ACT_W   = 3;
  localparam int CHANNELS = 4;

  localparam logic [31:0] UNLOCK_KEY = 32'h50D83AA1;

  localparam logic [ADDR_W-1:0] A_KEY    = 4'd0;
  localparam logic [ADDR_W-1:0] A_CTRL   = 4'd1;
  localparam logic [ADDR_W-1:0] A_HOLD0  = 4'd2;
  localparam logic [ADDR_W-1:0] A_FEED   = 4'd6;
  localparam logic [ADDR_W-1:0] A_INTEN  = 4'd7;
  localparam logic [ADDR_W-1:0] A_INTST  = 4'd8;
  localparam logic [ADDR_W-1:0] A_INTCLR = 4'd9;

  typedef enum logic [ACT_W-1:0] {
    ACT_NONE = 3'd0,
    ACT_IRQ  = 3'd1,
    ACT_CPU  = 3'd2,
    ACT_SYS  = 3'd3,
    ACT_AON  = 3'd4
  } actT;

  // configuration the control hands to the datapath
  typedef struct packed {
    logic               run;
    logic               clr;
    logic [LIMIT_W-1:0] limit;
    logic [CODE_W-1:0]  cpuCode;
    logic [CODE_W-1:0]  sysCode;
  } cfgT;

  // one-cycle action strobes
  typedef struct packed {
    logic cpu0;
    logic cpu1;
    logic sys;
    logic aon;
  } fireT;

  function automatic int codeNs(input logic [CODE_W-1:0] c);
    case (c)
      3'd0: return 100;
      3'd1: return 200;
      3'd2: return 300;
      3'd3: return 400;
      3'd4: return 500;
      3'd5: return 800;
      3'd6: return 1600;
      default: return 3200;
    endcase
  endfunction

  function automatic int codeCycles(input logic [CODE_W-1:0] c, input int periodPs);
    return (codeNs(c) * 1000 + periodPs - 1) / periodPs;
  endfunction
endpackage

// File: rtl/wdt_ctrl.sv
`timescale 1ns/1ps
module wdt_ctrl
  import wdt_pkg::*;
#(
  parameter logic [HOLD_W-1:0] HOLD_RST = 32'd1000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWe,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [31:0]       regWdata,
  output logic [31:0]       regRdata,
  input  logic [1:0]        fuseSel,
  input  logic              sleepIn,
  input  logic              expired,
  output cfgT               cfg,
  output fireT              fire,
  output logic [STAGE_W-1:0] stageOut,
  output logic              irqOut
);
  logic unlockQ, enQ, bootQ, pauseQ, cpu0EnQ, cpu1EnQ, intEnQ, intStQ;
  logic [CODE_W-1:0] cpuCodeQ, sysCodeQ;
  logic [ACT_W-1:0]  actQ  [STAGES];
  logic [HOLD_W-1:0] holdQ [STAGES];
  logic [STAGE_W-1:0] stageQ;

  logic wrOk, feedHit, clrHit, irqSet;
  logic [ACT_W-1:0]  actNow;
  logic [HOLD_W-1:0] curHold;
  logic [31:0] ctrlView;

  assign wrOk    = regWe && unlockQ;
  assign feedHit = wrOk && (regAddr == A_FEED) && regWdata[0];
  assign clrHit  = regWe && (regAddr == A_INTCLR) && regWdata[0];

  // key, control fields, interrupt enable
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      unlockQ  <= 1'b0;
      enQ      <= 1'b0;
      bootQ    <= 1'b0;
      pauseQ   <= 1'b0;
      cpu0EnQ  <= 1'b0;
      cpu1EnQ  <= 1'b0;
      cpuCodeQ <= '0;
      sysCodeQ <= '0;
      intEnQ   <= 1'b0;
    end else begin
      if (regWe && regAddr == A_KEY) unlockQ <= (regWdata == UNLOCK_KEY);
      if (wrOk && regAddr == A_CTRL) begin
        enQ      <= regWdata[0];
        bootQ    <= regWdata[1];
        pauseQ   <= regWdata[2];
        cpu0EnQ  <= regWdata[3];
        cpu1EnQ  <= regWdata[4];
        cpuCodeQ <= regWdata[7:5];
        sysCodeQ <= regWdata[10:8];
      end
      if (regWe && regAddr == A_INTEN) intEnQ <= regWdata[0];
    end
  end

  // per-stage action field and hold value
  for (genvar s = 0; s < STAGES; s++) begin : gStage
    localparam logic [ADDR_W-1:0] HOLD_ADDR = A_HOLD0 + ADDR_W'(s);
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        actQ[s]  <= ACT_NONE;
        holdQ[s] <= HOLD_RST;
      end else begin
        if (wrOk && regAddr == A_CTRL) actQ[s] <= regWdata[12+4*s +: ACT_W];
        if (wrOk && regAddr == HOLD_ADDR) holdQ[s] <= regWdata[HOLD_W-1:0];
      end
    end
  end

  assign actNow  = actQ[stageQ];
  assign curHold = holdQ[stageQ];

  // stage sequencer and interrupt status
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stageQ <= '0;
      intStQ <= 1'b0;
    end else begin
      if (feedHit) stageQ <= '0;
      else if (expired) stageQ <= (stageQ == STAGE_W'(STAGES-1)) ? '0 : stageQ + 1'b1;
      if (irqSet) intStQ <= 1'b1;
      else if (clrHit) intStQ <= 1'b0;
    end
  end

  assign irqSet = expired && (actNow == ACT_IRQ);

  always_comb begin
    cfg.run     = (enQ || bootQ) && !(pauseQ && sleepIn);
    cfg.clr     = feedHit;
    cfg.cpuCode = cpuCodeQ;
    cfg.sysCode = sysCodeQ;
    if (stageQ == '0)
      cfg.limit = {{(LIMIT_W-HOLD_W){1'b0}}, curHold} << (3'd1 + {1'b0, fuseSel});
    else
      cfg.limit = {{(LIMIT_W-HOLD_W){1'b0}}, curHold};
  end

  always_comb begin
    fire.cpu0 = expired && (actNow == ACT_CPU) && cpu0EnQ;
    fire.cpu1 = expired && (actNow == ACT_CPU) && cpu1EnQ;
    fire.sys  = expired && (actNow == ACT_SYS);
    fire.aon  = expired && (actNow == ACT_AON);
  end

  always_comb begin
    ctrlView = '0;
    ctrlView[10:0] = {sysCodeQ, cpuCodeQ, cpu1EnQ, cpu0EnQ, pauseQ, bootQ, enQ};
    for (int s = 0; s < STAGES; s++) ctrlView[12+4*s +: ACT_W] = actQ[s];
  end

  always_comb begin
    regRdata = '0;
    case (regAddr)
      A_KEY:   regRdata[0] = unlockQ;
      A_CTRL:  regRdata = ctrlView;
      A_FEED:  regRdata[STAGE_W-1:0] = stageQ;
      A_INTEN: regRdata[0] = intEnQ;
      A_INTST: regRdata[0] = intStQ;
      default: begin
        for (int s = 0; s < STAGES; s++)
          if (regAddr == A_HOLD0 + ADDR_W'(s)) regRdata[HOLD_W-1:0] = holdQ[s];
      end
    endcase
  end

  assign stageOut = stageQ;
  assign irqOut   = intStQ && intEnQ;
endmodule

// File: rtl/wdt_stretch.sv
`timescale 1ns/1ps
module wdt_stretch
  import wdt_pkg::*;
#(
  parameter int CLK_PS = 5000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              load,
  input  logic [CODE_W-1:0] code,
  output logic              active
);
  localparam int MAX_CYC = codeCycles(3'd7, CLK_PS);
  localparam int CW      = $clog2(MAX_CYC + 1);

  logic [CW-1:0] leftQ, loadVal;

  always_comb begin
    loadVal = '0;
    for (int c = 0; c < (1 << CODE_W); c++)
      if (code == CODE_W'(c)) loadVal = CW'(codeCycles(CODE_W'(c), CLK_PS));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) leftQ <= '0;
    else if (load) leftQ <= loadVal;
    else if (leftQ != '0) leftQ <= leftQ - 1'b1;
  end

  assign active = (leftQ != '0);
endmodule

// File: rtl/wdt_dpath.sv
`timescale 1ns/1ps
module wdt_dpath
  import wdt_pkg::*;
#(
  parameter int CLK_PS = 5000
) (
  input  logic clk,
  input  logic rstN,
  input  cfgT  cfg,
  input  fireT fire,
  output logic expired,
  output logic cpu0Rst,
  output logic cpu1Rst,
  output logic sysRst,
  output logic aonRst
);
  logic [LIMIT_W-1:0] cntQ, cntInc;
  logic [CHANNELS-1:0] fireVec, rstVec;

  assign cntInc  = cntQ + 1'b1;
  assign expired = cfg.run && !cfg.clr && (cntInc >= cfg.limit);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) cntQ <= '0;
    else if (cfg.clr || expired) cntQ <= '0;
    else if (cfg.run) cntQ <= cntInc;
  end

  assign fireVec = {fire.aon, fire.sys, fire.cpu1, fire.cpu0};

  // channels 0,1 use the CPU width code, 2,3 the system code
  for (genvar g = 0; g < CHANNELS; g++) begin : gCh
    wdt_stretch #(.CLK_PS(CLK_PS)) u_stretch (
      .clk    (clk),
      .rstN   (rstN),
      .load   (fireVec[g]),
      .code   ((g < 2) ? cfg.cpuCode : cfg.sysCode),
      .active (rstVec[g])
    );
  end

  assign cpu0Rst = rstVec[0];
  assign cpu1Rst = rstVec[1];
  assign sysRst  = rstVec[2];
  assign aonRst  = rstVec[3];
endmodule

// File: rtl/tiered_wdt.sv
`timescale 1ns/1ps
module tiered_wdt
  import wdt_pkg::*;
#(
  parameter int CLK_PS = 5000,
  parameter logic [HOLD_W-1:0] HOLD_RST = 32'd1000
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        regWe,
  input  logic [3:0]  regAddr,
  input  logic [31:0] regWdata,
  output logic [31:0] regRdata,
  input  logic [1:0]  fuseSel,
  input  logic        sleepIn,
  output logic        irqOut,
  output logic        cpu0Rst,
  output logic        cpu1Rst,
  output logic        sysRst,
  output logic        aonRst
);
  cfgT  cfg;
  fireT fire;
  logic expired;
  logic [STAGE_W-1:0] stageOut;

  wdt_ctrl #(.HOLD_RST(HOLD_RST)) u_ctrl (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .fuseSel(fuseSel),
    .sleepIn(sleepIn), .expired(expired), .cfg(cfg), .fire(fire),
    .stageOut(stageOut), .irqOut(irqOut)
  );

  wdt_dpath #(.CLK_PS(CLK_PS)) u_dpath (
    .clk(clk), .rstN(rstN), .cfg(cfg), .fire(fire), .expired(expired),
    .cpu0Rst(cpu0Rst), .cpu1Rst(cpu1Rst), .sysRst(sysRst), .aonRst(aonRst)
  );
endmodule

// File: rtl/tiered_wdt_chk.sv
`timescale 1ns/1ps
module tiered_wdt_chk
  import wdt_pkg::*;
(
  input logic clk,
  input logic rstN,
  input cfgT  cfg,
  input fireT fire,
  input logic expired,
  input logic [STAGE_W-1:0] stageOut,
  input logic cpu1Rst,
  input logic sysRst
);
  // R2
  stage_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    expired |=> stageOut == STAGE_W'($past(stageOut) + 1'b1));

  // R7
  feed_clr_chk: assert property (@(posedge clk) disable iff (!rstN)
    cfg.clr |=> stageOut == '0);

  // R5
  sys_rise_chk: assert property (@(posedge clk) disable iff (!rstN)
    fire.sys |=> sysRst);

  // R6
  cpu1_src_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(cpu1Rst) |-> $past(fire.cpu1));

  // R4
  one_action_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({fire.sys, fire.aon, (fire.cpu0 || fire.cpu1)}));

  // R8
  idle_still_chk: assert property (@(posedge clk) disable iff (!rstN)
    !cfg.run |=> $stable(stageOut) || $past(cfg.clr));
endmodule

bind tiered_wdt tiered_wdt_chk u_chk (
  .clk(clk), .rstN(rstN), .cfg(cfg), .fire(fire), .expired(expired),
  .stageOut(stageOut), .cpu1Rst(cpu1Rst), .sysRst(sysRst)
);

// File: tb/tiered_wdt_bench.sv
`timescale 1ns/1ps
module tiered_wdt_bench;
  localparam int CLK_PS = 5000;
  localparam logic [31:0] KEY = 32'h50D83AA1;

  logic clk = 0, rstN = 0, regWe = 0, sleepIn = 0;
  logic [3:0] regAddr = 0;
  logic [31:0] regWdata = 0;
  logic [1:0] fuseSel = 0;
  logic [31:0] regRdata;
  logic irqOut, cpu0Rst, cpu1Rst, sysRst, aonRst;
  int checks = 0, errors = 0;
  logic sysSeen = 0, anySeen = 0;

  tiered_wdt #(.CLK_PS(CLK_PS)) u_tiered_wdt (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr), .regWdata(regWdata),
    .regRdata(regRdata), .fuseSel(fuseSel), .sleepIn(sleepIn), .irqOut(irqOut),
    .cpu0Rst(cpu0Rst), .cpu1Rst(cpu1Rst), .sysRst(sysRst), .aonRst(aonRst)
  );

  always #2.5 clk = ~clk;

  always @(posedge clk) begin
    #1;
    if (sysRst) sysSeen = 1;
    if (sysRst || cpu0Rst || cpu1Rst || aonRst || irqOut) anySeen = 1;
  end

  task automatic summary;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=hung expected=done");
    summary();
  end

  task automatic chk(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int benchWidth(input int c);
    int ns;
    case (c)
      0: ns = 100;  1: ns = 200;  2: ns = 300;  3: ns = 400;
      4: ns = 500;  5: ns = 800;  6: ns = 1600; default: ns = 3200;
    endcase
    return (ns * 1000 + CLK_PS - 1) / CLK_PS;
  endfunction

  function automatic logic [31:0] mkCtrl(input int en, boot, pause, c0, c1,
                                         cpuC, sysC, a0, a1, a2, a3);
    logic [31:0] w = 0;
    w[0] = en[0]; w[1] = boot[0]; w[2] = pause[0]; w[3] = c0[0]; w[4] = c1[0];
    w[7:5] = cpuC[2:0]; w[10:8] = sysC[2:0];
    w[14:12] = a0[2:0]; w[18:16] = a1[2:0]; w[22:20] = a2[2:0]; w[26:24] = a3[2:0];
    return w;
  endfunction

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    regWe = 1; regAddr = a; regWdata = d;
    @(negedge clk);
    regWe = 0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    regAddr = a;
    #0.5;
    d = regRdata;
  endtask

  function automatic logic sigOf(input int w);
    case (w)
      0: return sysRst;
      1: return cpu0Rst;
      2: return cpu1Rst;
      3: return aonRst;
      default: return irqOut;
    endcase
  endfunction

  task automatic waitRise(input int which, input int sleepRel, input int maxN, output int n);
    n = 0;
    forever begin
      @(negedge clk);
      n++;
      if (n == sleepRel) sleepIn = 0;
      if (sigOf(which) || n > maxN) break;
    end
  endtask

  task automatic quiesce;
    wr(0, KEY);
    wr(1, 0);
    wr(6, 1);
    sleepIn = 0;
    repeat (660) @(negedge clk);
    wr(9, 1);
    for (int s = 1; s < 4; s++) wr(4'(2 + s), 2000);
    sysSeen = 0;
    anySeen = 0;
  endtask

  initial begin
    logic [31:0] d, v;
    int n, w, h0, h1, h2, h3, s, tInt, tCpu, tSys, fInt, fCpu, fSys;
    logic c1Seen;
    void'($urandom(32'hC0FFEE));

    repeat (4) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    // R11 reset state
    chk("R11 outputs", {irqOut, cpu0Rst, cpu1Rst, sysRst, aonRst}, 0);
    rd(1, d); chk("R11 ctrl", d, 0);
    rd(6, d); chk("R11 stage", d, 0);

    // R1 lock behaviour
    rd(0, d); chk("R1 locked after reset", d, 0);
    wr(1, 32'h1F); rd(1, d); chk("R1 locked ctrl write ignored", d, 0);
    wr(0, KEY); rd(0, d); chk("R1 unlock", d, 1);
    v = $urandom() & 32'h077777FE;
    wr(1, v); rd(1, d); chk("R1 unlocked write", d, v);
    wr(0, KEY ^ 32'h1); rd(0, d); chk("R1 near-miss key locks", d, 0);
    wr(1, 32'h0); rd(1, d); chk("R1 write while locked ignored", d, v);
    wr(3, 32'h55); rd(3, d); chk("R1 hold write while locked", d, 1000);

    // R3 stage-0 scaling
    for (int i = 0; i < 6; i++) begin
      h0 = $urandom_range(1, 12);
      s = $urandom_range(0, 3);
      fuseSel = 2'(s);
      quiesce();
      wr(2, h0);
      wr(1, mkCtrl(1,0,0,0,0, 0,0, 3,0,0,0));
      waitRise(0, -1, 5000, n);
      chk("R3 stage0 scaled timeout", n, h0 << (1 + s));
    end
    fuseSel = 0;

    // R5 system pulse widths for every code
    for (int c = 0; c < 8; c++) begin
      quiesce();
      wr(2, 5);
      wr(1, mkCtrl(1,0,0,0,0, 0,c, 3,0,0,0));
      waitRise(0, -1, 100, n);
      w = 0;
      while (sysRst && w < 2000) begin w++; @(negedge clk); end
      chk($sformatf("R5 sys width code %0d", c), w, benchWidth(c));
    end
    // R5 cpu pulse widths
    for (int i = 0; i < 2; i++) begin
      int c = $urandom_range(0, 7);
      quiesce();
      wr(2, 5);
      wr(1, mkCtrl(1,0,0,1,0, c,0, 2,0,0,0));
      waitRise(1, -1, 100, n);
      w = 0;
      while (cpu0Rst && w < 2000) begin w++; @(negedge clk); end
      chk($sformatf("R5 cpu width code %0d", c), w, benchWidth(c));
    end

    // R2 / R4 chained stages: none, irq, cpu, sys, then wrap
    quiesce();
    h0 = $urandom_range(1, 8); h1 = $urandom_range(1, 8);
    h2 = $urandom_range(1, 8); h3 = $urandom_range(1, 8);
    wr(2, h0); wr(3, h1); wr(4, h2); wr(5, h3);
    wr(7, 1);
    wr(1, mkCtrl(1,0,0,1,0, 0,0, 0,1,2,3));
    tInt = 2 * h0 + h1; tCpu = tInt + h2; tSys = tCpu + h3;
    fInt = -1; fCpu = -1; fSys = -1; c1Seen = 0;
    for (int k = 1; k <= tSys + 2; k++) begin
      @(negedge clk);
      if (irqOut && fInt < 0) fInt = k;
      if (cpu0Rst && fCpu < 0) fCpu = k;
      if (cpu1Rst) c1Seen = 1;
      if (sysRst && fSys < 0) begin
        fSys = k;
        rd(6, d); chk("R2 wrap to stage 0", d, 0);
      end
    end
    chk("R4 irq action timing", fInt, tInt);
    chk("R4 cpu action timing", fCpu, tCpu);
    chk("R4 sys action timing", fSys, tSys);
    chk("R6 cpu1 disabled", c1Seen, 0);

    // R6 cpu1 only
    quiesce();
    wr(2, 3);
    wr(1, mkCtrl(1,0,0,0,1, 0,0, 2,0,0,0));
    waitRise(2, -1, 100, n);
    chk("R6 cpu1 fires", n, 6);
    chk("R6 cpu0 stays low", cpu0Rst, 0);

    // R4 always-on action and reserved code
    quiesce();
    wr(2, 3);
    wr(1, mkCtrl(1,0,0,0,0, 0,2, 4,0,0,0));
    waitRise(3, -1, 100, n);
    chk("R4 aon action", n, 6);
    quiesce();
    wr(2, 3);
    wr(1, mkCtrl(1,0,0,1,1, 0,0, 5,0,0,0));
    repeat (40) @(negedge clk);
    chk("R4 reserved code no output", anySeen, 0);
    rd(6, d); chk("R2 off stage advances", d, 1);

    // R7 feeding holds off expiry
    quiesce();
    wr(2, 10);
    wr(1, mkCtrl(1,0,0,0,0, 0,0, 3,0,0,0));
    for (int i = 0; i < 10; i++) begin
      repeat (8) @(negedge clk);
      wr(6, 1);
    end
    chk("R7 fed no reset", sysSeen, 0);
    rd(6, d); chk("R7 stage after feed", d, 0);
    wr(0, 0);
    for (int i = 0; i < 5; i++) begin
      repeat (8) @(negedge clk);
      wr(6, 1);
    end
    chk("R1 feed ignored while locked", sysSeen, 1);

    // R8 boot mode and idle
    quiesce();
    wr(2, 4);
    wr(1, mkCtrl(0,1,0,0,0, 0,0, 3,0,0,0));
    waitRise(0, -1, 100, n);
    chk("R8 boot mode fires", n, 8);
    quiesce();
    wr(2, 4);
    wr(1, mkCtrl(0,0,0,0,0, 0,0, 3,0,0,0));
    repeat (100) @(negedge clk);
    chk("R8 idle no reset", sysSeen, 0);
    rd(6, d); chk("R8 idle stage", d, 0);

    // R9 pause in sleep
    quiesce();
    s = $urandom_range(5, 30);
    wr(2, 6);
    sleepIn = 1;
    wr(1, mkCtrl(1,0,1,0,0, 0,0, 3,0,0,0));
    waitRise(0, s, 500, n);
    chk("R9 frozen in sleep", n, s + 12);
    quiesce();
    wr(2, 6);
    sleepIn = 1;
    wr(1, mkCtrl(1,0,0,0,0, 0,0, 3,0,0,0));
    waitRise(0, -1, 500, n);
    sleepIn = 0;
    chk("R9 sleep ignored without pause", n, 12);

    // R10 interrupt status, enable, clear
    quiesce();
    wr(7, 0);
    wr(2, 3);
    wr(1, mkCtrl(1,0,0,0,0, 0,0, 1,0,0,0));
    repeat (10) @(negedge clk);
    rd(8, d); chk("R10 status set", d, 1);
    chk("R10 masked irq", irqOut, 0);
    wr(0, 0);
    wr(7, 1);
    chk("R10 enabled irq", irqOut, 1);
    wr(9, 1);
    rd(8, d); chk("R10 status cleared", d, 0);
    chk("R10 irq after clear", irqOut, 0);

    summary();
  end
endmodule